// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin-Change Interrupt

This block is an eight-bit general-purpose I/O port that a processor core reaches through a small register bus. It holds an output latch, a per-bit direction latch and one active-low control bit that enables weak pull-ups on every pin. The pin side of the block gives each pad its output value, its output enable and its pull-up enable. It takes the raw pad levels back in and passes them through a two-flop synchronizer before any other logic uses them.

The upper four pins can raise a change interrupt. Each of these pins is compared with a snapshot of its level, and the snapshot is taken only when software reads the port. While any of the four inputs differs from its snapshot, the flag is set again on every cycle. Software must therefore read the port to end the mismatch before a clear of the flag takes effect. The flag also drives a wake request for a sleeping core. A peripheral override input can force any pin to input or output while that peripheral is active.

Top module: `gpio_chg_port`

## Requirements
- R1: Register select 0 is the port. A write to it always loads the output latch, including bits that are set as inputs, and `pin_out` always shows the latch. With no override, direction bit 1 gives `pin_oe`=0 (input) and direction bit 0 gives `pin_oe`=1.
- R2: Register select 2 is the option register. Bit 0 of it is the active-low pull-up control. `pin_pu[i]` is 1 exactly when that bit is 0 and pin i is an input after any override.
- R3: After reset the direction register reads 0xFF, the output latch is 0x00, the option register reads 0x01, the change flag is 0 and no pull-up is on.
- R4: A read of the port (select 0) returns the pin levels after two clock edges of synchronization, not the output latch.
- R5: Only bits 7..4 take part in change detection. A change on bits 3..0, or on an upper bit that is currently an output, never sets the flag.
- R6: When an upper input pin differs from its snapshot, the flag is 1 after the following edge. It is set again on every edge while the mismatch lasts, so a clear on the same edge loses to the set.
- R7: A read of the port loads the snapshot from the synchronized pins. Once the mismatch is gone, a write of 1 to bit 0 of register select 3 clears the flag. A read of select 3 returns the flag in bit 0.
- R8: `wake_req` and `chg_irq` are both high whenever the change flag is set.
- R9: Where `ovr_en[i]`=1, pin i takes its direction from `ovr_dir[i]` (1 = input) instead of the direction register. A read of the direction register (select 1) still returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 port, 1 direction, 2 option, 3 flag |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Raw pad input levels |
| pin_out | output | 8 | Output latch value for the pads |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| ovr_en | input | 8 | Per-pin peripheral direction override enable |
| ovr_dir | input | 8 | Override direction, 1 = input |
| chg_irq | output | 1 | Change interrupt flag |
| wake_req | output | 1 | Wake request from the change flag |

## Verification
The assertions assume that the bus strobes are clean single-cycle pulses with a stable select and data, and that only one of the read and write strobes is active in a cycle. They also assume that `pin_in` may change at any time, since the synchronizer makes it safe. The bench drives every input just after the falling edge, never raises both strobes together, and holds each strobe high for exactly one rising edge. The only exception is one deliberate multi-cycle read, which checks the synchronizer latency while the snapshot is reloaded on each edge.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
    typedef enum logic [1:0] {
        REG_PORT = 2'd0,
        REG_DIR  = 2'd1,
        REG_OPT  = 2'd2,
        REG_FLAG = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];

    // each stage follows its predecessor by one edge
    for (genvar k = 1; k < STAGES; k++) begin : g_chk
        assert_sync_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
            stg_q[k] == $past(stg_q[k-1]));
    end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_reg,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_dir,
    input  logic             pu_n,
    output logic [WIDTH-1:0] eff_in,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        always_comb begin
            eff_in[i] = ovr_en[i] ? ovr_dir[i] : dir_reg[i];
            oe[i]     = ~eff_in[i];
            pu[i]     = ~pu_n & eff_in[i];
        end
    end
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
    parameter int CHG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHG_W-1:0] lvl,
    input  logic [CHG_W-1:0] is_in,
    input  logic             snap_ld,
    input  logic             clr_req,
    output logic             flag
);
    typedef struct packed {
        logic [CHG_W-1:0] snap;
        logic             flag;
    } det_t;

    det_t det_d, det_q;
    logic [CHG_W-1:0] mism;
    logic             mism_any;

    always_comb begin
        mism     = is_in & (lvl ^ det_q.snap);
        mism_any = |mism;
        det_d    = det_q;
        if (snap_ld) det_d.snap = lvl;
        if (mism_any)     det_d.flag = 1'b1;
        else if (clr_req) det_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign flag = det_q.flag;

    assert_mismatch_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mism_any |=> flag);
    assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    assert_clear_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !mism_any) |=> !flag);
    assert_snap_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap_ld |=> det_q.snap == $past(lvl));
    assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !mism_any) |=> !flag);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
    import gpio_chg_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int CHG_LO      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_pu,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_dir,
    output logic             chg_irq,
    output logic             wake_req
);
    localparam int CHG_W = WIDTH - CHG_LO;

    typedef struct packed {
        logic [WIDTH-1:0] out;
        logic [WIDTH-1:0] dir;
        logic             pu_n;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [WIDTH-1:0] lvl_sync;
    logic [WIDTH-1:0] eff_in;
    logic             port_rd;
    logic             flag_clr;
    logic             flag;
    gpio_reg_e        sel;

    assign sel = gpio_reg_e'(bus_sel);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(lvl_sync));

    gpio_pin_ctl #(.WIDTH(WIDTH)) u_pins (
        .dir_reg(regs_q.dir), .ovr_en(ovr_en), .ovr_dir(ovr_dir),
        .pu_n(regs_q.pu_n), .eff_in(eff_in), .oe(pin_oe), .pu(pin_pu));

    gpio_chg_det #(.CHG_W(CHG_W)) u_det (
        .clk(clk), .rst_n(rst_n),
        .lvl(lvl_sync[WIDTH-1:CHG_LO]), .is_in(eff_in[WIDTH-1:CHG_LO]),
        .snap_ld(port_rd), .clr_req(flag_clr), .flag(flag));

    always_comb begin
        port_rd  = bus_rd && (sel == REG_PORT);
        flag_clr = bus_wr && (sel == REG_FLAG) && bus_wdata[0];
        regs_d   = regs_q;
        if (bus_wr) begin
            unique case (sel)
                REG_PORT: regs_d.out  = bus_wdata;
                REG_DIR:  regs_d.dir  = bus_wdata;
                REG_OPT:  regs_d.pu_n = bus_wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.out  <= '0;
            regs_q.dir  <= '1;
            regs_q.pu_n <= 1'b1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_PORT: bus_rdata = lvl_sync;
            REG_DIR:  bus_rdata = regs_q.dir;
            REG_OPT:  bus_rdata[0] = regs_q.pu_n;
            REG_FLAG: bus_rdata[0] = flag;
            default:  ;
        endcase
    end

    assign pin_out  = regs_q.out;
    assign chg_irq  = flag;
    assign wake_req = flag;

    assert_data_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_PORT) |=> pin_out == $past(bus_wdata));
    assert_pu_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.pu_n |-> pin_pu == '0);
    assert_pu_input_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);
    assert_dir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_DIR) |=> regs_q.dir == $past(bus_wdata));
    assert_ovr_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en & ovr_dir & pin_oe) == '0);
endmodule

// File: tb/test_gpio_chg_port.sv
module test_gpio_chg_port;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pin_in = '0, pin_out, pin_oe, pin_pu;
    logic [7:0] ovr_en = '0, ovr_dir = '0;
    logic       chg_irq, wake_req;
    int total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_chg_port i_gpio_chg_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .ovr_en(ovr_en),
        .ovr_dir(ovr_dir), .chg_irq(chg_irq), .wake_req(wake_req));

    // rows: dir, option, data, ovr_en, ovr_dir
    localparam logic [39:0] VEC [6] = '{
        {8'hFF, 8'h01, 8'h00, 8'h00, 8'h00},
        {8'h00, 8'h00, 8'hA5, 8'h00, 8'h00},
        {8'hF0, 8'h00, 8'h3C, 8'h00, 8'h00},
        {8'h0F, 8'h01, 8'hC3, 8'h00, 8'h00},
        {8'hFF, 8'h00, 8'h5A, 8'h0F, 8'h05},
        {8'h00, 8'h00, 8'hFF, 8'hF0, 8'hA0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] eff;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R3 reset state
        check("R3 pin_out", pin_out, 8'h00);
        check("R3 pin_oe", pin_oe, 8'h00);
        check("R3 pin_pu", pin_pu, 8'h00);
        check("R3 irq", {7'd0, chg_irq}, 8'h00);
        rd(2'd1, d); check("R3 dir read", d, 8'hFF);
        rd(2'd2, d); check("R3 opt read", d, 8'h01);
        rd(2'd3, d); check("R3 flag read", d, 8'h00);

        // R1 R2 R9 table of register settings
        for (int r = 0; r < 6; r++) begin
            wr(2'd1, VEC[r][39:32]);
            wr(2'd2, VEC[r][31:24]);
            wr(2'd0, VEC[r][23:16]);
            ovr_en  = VEC[r][15:8];
            ovr_dir = VEC[r][7:0];
            #1;
            eff = (ovr_en & ovr_dir) | (~ovr_en & VEC[r][39:32]);
            check("R1 pin_out", pin_out, VEC[r][23:16]);
            check("R1/R9 pin_oe", pin_oe, ~eff);
            check("R2 pin_pu", pin_pu, VEC[r][24] ? 8'h00 : eff);
            rd(2'd1, d); check("R9 dir readback", d, VEC[r][39:32]);
        end
        ovr_en = '0; ovr_dir = '0;
        wr(2'd1, 8'hFF); wr(2'd2, 8'h01);

        // R1 latch written while all inputs, then turned to outputs
        wr(2'd0, 8'h96);
        check("R1 latch while input", pin_out, 8'h96);
        wr(2'd1, 8'h00);
        check("R1 oe after dir 0", pin_oe, 8'hFF);
        wr(2'd1, 8'hFF);

        // R5 low bit change ignored
        rd(2'd0, d);
        @(negedge clk); pin_in = 8'h01;
        wait_cyc(4);
        check("R5 low bit no flag", {7'd0, chg_irq}, 8'h00);

        // R6 timing of flag set on bit 4
        pin_in = 8'h11;
        wait_cyc(2);
        check("R6 flag not yet", {7'd0, chg_irq}, 8'h00);
        wait_cyc(1);
        check("R6 flag set", {7'd0, chg_irq}, 8'h01);
        check("R8 wake", {7'd0, wake_req}, 8'h01);
        wr(2'd3, 8'h01);
        check("R6 clear lost to mismatch", {7'd0, chg_irq}, 8'h01);
        rd(2'd3, d); check("R7 flag read", d, 8'h01);
        rd(2'd0, d); check("R4 port read", d, 8'h11);
        wr(2'd3, 8'h01);
        check("R7 clear after read", {7'd0, chg_irq}, 8'h00);
        check("R8 wake low", {7'd0, wake_req}, 8'h00);

        // R5 output-configured upper bit ignored
        wr(2'd1, 8'hEF);
        @(negedge clk); pin_in = 8'h01;
        wait_cyc(4);
        check("R5 output bit no flag", {7'd0, chg_irq}, 8'h00);
        pin_in = 8'h11;
        wait_cyc(4);
        wr(2'd1, 8'hFF);
        wait_cyc(2);
        check("R5 restored no flag", {7'd0, chg_irq}, 8'h00);

        // R4 two-edge synchronizer latency
        @(negedge clk);
        pin_in = 8'h93; bus_sel = 2'd0; bus_rd = 1'b1;
        #1 check("R4 before edges", bus_rdata, 8'h11);
        @(negedge clk); #1 check("R4 after one edge", bus_rdata, 8'h11);
        @(negedge clk); #1 check("R4 after two edges", bus_rdata, 8'h93);
        bus_rd = 1'b0;
        wait_cyc(2);
        check("R6 bit7 flag", {7'd0, chg_irq}, 8'h01);
        rd(2'd0, d);
        wr(2'd3, 8'h01);
        check("R7 cleared again", {7'd0, chg_irq}, 8'h00);

        // R9 override forces output, register unchanged
        ovr_en = 8'h20; ovr_dir = 8'h00;
        #1 check("R9 override oe", pin_oe, 8'h20);
        rd(2'd1, d); check("R9 dir unaffected", d, 8'hFF);
        ovr_en = 8'h00;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule